// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register front end of a multi-channel interval timer. A small address space reaches it: one address per channel counter and one control address (address 3). Writes to the control address carry control words. A control word either reprograms one channel's access style, counting mode and BCD flag, or freezes that channel's count. It can also be a read-back command that freezes count and/or status for any set of channels at once. Writes and reads at a channel address are sequenced byte by byte according to that channel's access style.

Each channel's counting logic sits outside this block. The block hands each channel a 16-bit reload value with a one-cycle load strobe and the current mode. It takes back the live count and the output level from each channel. Latched values are held until software has read them, so a multi-byte read stays coherent while the counter keeps running.

Top module: `tmr_front`

## Requirements
- R1: After reset every channel is in word access (LSB then MSB), mode 0, BCD 0, with both byte pointers at the low byte and no latches pending. `rdData`, `loadStb` and `chanMode` are all zero.
- R2: A control write selects the channel with bits 7:6 (value 3 means read-back). A nonzero access field in bits 5:4 (1 low byte, 2 high byte, 3 word) stores that access style, the mode from bits 3:1 and BCD from bit 0. Modes 6 and 7 are stored as 2 and 3. Both byte pointers of that channel return to the low byte.
- R3: In low-byte access, a data write drives `reloadVal` with the byte in bits 7:0 and zero above it. The channel's `loadStb` bit pulses for one cycle, in the cycle after the write.
- R4: In high-byte access, a data write reloads the byte in bits 15:8 with zero below it, timed as in R3.
- R5: In word access, the first data write is held without a strobe. The second loads {second byte, first byte}, and the sequence then starts over.
- R6: Access field 0 in a control word latches the live count of the selected channel. A further count latch on a channel whose latched count is still unread has no effect.
- R7: In a read-back command, bits 1, 2 and 3 select channels 0, 1 and 2; several may be set. Bit 5 low latches the count and bit 4 low latches the status of each selected channel.
- R8: The status byte is {output level, 0, access style[1:0], mode[2:0], BCD}, captured at latch time. A further status latch while one is unread has no effect.
- R9: A read of a channel returns its pending status first, and that read clears the status latch. A pending count is returned only once no status is pending.
- R10: A latched count is returned low byte then high byte in word access and then released. In low-byte or high-byte access it is returned as that single byte and released after one read. Reading a latched count does not move the live read pointer.
- R11: With no latch pending, a read returns the live count's low or high byte as the access style selects. In word access it alternates, starting with the low byte.
- R12: Read data appears on `rdData` in the cycle after the read strobe and is held until the next read. A read of the control address returns 0x00. If both strobes are high, the write is taken and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Register address: channel 0..2, or 3 for control |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid the cycle after `rdEn` |
| liveCount | input | CH_NUM*CNT_W | Live count of each channel, channel 0 in the low bits |
| chanOut | input | CH_NUM | Output level of each channel |
| reloadVal | output | CH_NUM*CNT_W | Reload value for each channel |
| loadStb | output | CH_NUM | One-cycle reload strobe for each channel |
| chanMode | output | CH_NUM*3 | Programmed mode for each channel |

## Verification
The bench builds the block with its defaults: three channels and 16-bit counts. This is the only width at which the byte sequencing, both single-byte access styles and word access all apply. With three channels the read-back command can select a strict subset (channels 0 and 1 together, then channel 2 alone), so the bench can see that unselected channels stay unlatched. Holding fixed live counts and changing them between latch and read separates frozen values from live ones. The same holds for the output level between two status latches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LOW   = 2'd1,
    ACC_HIGH  = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  // Per-channel strobes from the control decoder to the datapath
  typedef struct packed {
    logic cfgWr;
    logic latchCnt;
    logic latchSts;
    logic dataWr;
    logic dataRd;
  } chStb_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CH_NUM = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output chStb_t     stb [CH_NUM],
  output acc_e       cfgAcc,
  output logic [2:0] cfgMode,
  output logic       cfgBcd,
  output logic       rdFire
);

  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic       ctrlWr;
  logic       readBack;
  logic [1:0] chanSel;
  logic [1:0] accField;

  assign ctrlWr   = wrEn && (addr == CTRL_ADDR);
  assign chanSel  = wrData[7:6];
  assign accField = wrData[5:4];
  assign readBack = ctrlWr && (chanSel == 2'd3);
  assign rdFire   = rdEn && !wrEn;

  always_comb begin
    cfgAcc  = acc_e'(accField);
    cfgBcd  = wrData[0];
    cfgMode = wrData[3:1];
    if (cfgMode > 3'd5) cfgMode = {1'b0, cfgMode[1:0]};
  end

  for (genvar g = 0; g < CH_NUM; g++) begin : g_dec
    always_comb begin
      stb[g] = '0;
      if (ctrlWr && !readBack && chanSel == 2'(g)) begin
        stb[g].cfgWr    = (accField != 2'd0);
        stb[g].latchCnt = (accField == 2'd0);
      end
      if (readBack && wrData[g+1]) begin
        stb[g].latchCnt = !wrData[5];
        stb[g].latchSts = !wrData[4];
      end
      stb[g].dataWr = wrEn && (addr == 2'(g));
      stb[g].dataRd = rdFire && (addr == 2'(g));
    end

    // R7: a read-back command never reprograms a channel
    a_r7_readback_no_cfg: assert property (@(posedge clk) disable iff (!rstN)
      readBack |-> !stb[g].cfgWr);
  end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chStb_t           stb,
  input  acc_e             cfgAcc,
  input  logic [2:0]       cfgMode,
  input  logic             cfgBcd,
  input  logic [7:0]       wrByte,
  input  logic [CNT_W-1:0] liveCnt,
  input  logic             outLvl,
  output logic [CNT_W-1:0] reload,
  output logic             loadPulse,
  output logic [2:0]       mode,
  output logic [7:0]       rdByte
);

  localparam int BYTE_W = CNT_W / 2;

  acc_e              accR;
  logic              bcdR;
  logic              wrHi;
  logic              rdHi;
  logic [BYTE_W-1:0] holdByte;
  logic              cntValid;
  logic              cntHiNext;
  logic [CNT_W-1:0]  cntLatch;
  logic              stsValid;
  logic [7:0]        stsByte;

  always_comb begin
    if (stsValid)      rdByte = stsByte;
    else if (cntValid) rdByte = cntHiNext ? cntLatch[CNT_W-1:BYTE_W] : cntLatch[BYTE_W-1:0];
    else begin
      unique case (accR)
        ACC_HIGH: rdByte = liveCnt[CNT_W-1:BYTE_W];
        ACC_WORD: rdByte = rdHi ? liveCnt[CNT_W-1:BYTE_W] : liveCnt[BYTE_W-1:0];
        default:  rdByte = liveCnt[BYTE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accR      <= ACC_WORD;
      mode      <= '0;
      bcdR      <= 1'b0;
      wrHi      <= 1'b0;
      rdHi      <= 1'b0;
      holdByte  <= '0;
      cntValid  <= 1'b0;
      cntHiNext <= 1'b0;
      cntLatch  <= '0;
      stsValid  <= 1'b0;
      stsByte   <= '0;
      reload    <= '0;
      loadPulse <= 1'b0;
    end else begin
      loadPulse <= 1'b0;
      if (stb.cfgWr) begin
        accR <= cfgAcc;
        mode <= cfgMode;
        bcdR <= cfgBcd;
        wrHi <= 1'b0;
        rdHi <= 1'b0;
      end
      if (stb.latchCnt && !cntValid) begin
        cntLatch  <= liveCnt;
        cntValid  <= 1'b1;
        cntHiNext <= (accR == ACC_HIGH);
      end
      if (stb.latchSts && !stsValid) begin
        stsByte  <= {outLvl, 1'b0, accR, mode, bcdR};
        stsValid <= 1'b1;
      end
      if (stb.dataWr) begin
        unique case (accR)
          ACC_HIGH: begin
            reload    <= {wrByte, {BYTE_W{1'b0}}};
            loadPulse <= 1'b1;
          end
          ACC_WORD: begin
            if (!wrHi) begin
              holdByte <= wrByte;
              wrHi     <= 1'b1;
            end else begin
              reload    <= {wrByte, holdByte};
              loadPulse <= 1'b1;
              wrHi      <= 1'b0;
            end
          end
          default: begin
            reload    <= {{BYTE_W{1'b0}}, wrByte};
            loadPulse <= 1'b1;
          end
        endcase
      end
      if (stb.dataRd) begin
        if (stsValid) stsValid <= 1'b0;
        else if (cntValid) begin
          if (accR == ACC_WORD && !cntHiNext) cntHiNext <= 1'b1;
          else cntValid <= 1'b0;
        end else if (accR == ACC_WORD) rdHi <= !rdHi;
      end
    end
  end

  // R2: programming restarts both byte sequences
  a_r2_ptr_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr |=> (!wrHi && !rdHi));
  // R3: a reload strobe only ever follows a data write
  a_r3_load_after_write: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |-> $past(stb.dataWr));
  // R6: an unread count latch is not overwritten
  a_r6_latch_once: assert property (@(posedge clk) disable iff (!rstN)
    (cntValid && stb.latchCnt && !stb.dataRd) |=> $stable(cntLatch));
  // R9: a pending status survives until it is read
  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stsValid && !stb.dataRd) |=> (stsValid && $stable(stsByte)));

endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CH_NUM = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chStb_t                  stb [CH_NUM],
  input  acc_e                    cfgAcc,
  input  logic [2:0]              cfgMode,
  input  logic                    cfgBcd,
  input  logic                    rdFire,
  input  logic [7:0]              wrByte,
  input  logic [CH_NUM*CNT_W-1:0] liveCount,
  input  logic [CH_NUM-1:0]       chanOut,
  output logic [CH_NUM*CNT_W-1:0] reloadVal,
  output logic [CH_NUM-1:0]       loadStb,
  output logic [CH_NUM*3-1:0]     chanMode,
  output logic [7:0]              rdData
);

  logic [7:0] chByte [CH_NUM];
  logic [7:0] selByte;

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (stb[g]),
      .cfgAcc    (cfgAcc),
      .cfgMode   (cfgMode),
      .cfgBcd    (cfgBcd),
      .wrByte    (wrByte),
      .liveCnt   (liveCount[g*CNT_W +: CNT_W]),
      .outLvl    (chanOut[g]),
      .reload    (reloadVal[g*CNT_W +: CNT_W]),
      .loadPulse (loadStb[g]),
      .mode      (chanMode[g*3 +: 3]),
      .rdByte    (chByte[g])
    );
  end

  always_comb begin
    selByte = '0;
    for (int i = 0; i < CH_NUM; i++)
      if (stb[i].dataRd) selByte = chByte[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)       rdData <= '0;
    else if (rdFire) rdData <= selByte;
  end

  // R12: read data holds between reads
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdFire |=> $stable(rdData));

endmodule

// File: rtl/tmr_front.sv
module tmr_front
  import tmr_pkg::*;
#(
  parameter int CH_NUM = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [1:0]              addr,
  input  logic [7:0]              wrData,
  output logic [7:0]              rdData,
  input  logic [CH_NUM*CNT_W-1:0] liveCount,
  input  logic [CH_NUM-1:0]       chanOut,
  output logic [CH_NUM*CNT_W-1:0] reloadVal,
  output logic [CH_NUM-1:0]       loadStb,
  output logic [CH_NUM*3-1:0]     chanMode
);

  chStb_t     stb [CH_NUM];
  acc_e       cfgAcc;
  logic [2:0] cfgMode;
  logic       cfgBcd;
  logic       rdFire;

  tmr_ctrl #(.CH_NUM(CH_NUM)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .stb     (stb),
    .cfgAcc  (cfgAcc),
    .cfgMode (cfgMode),
    .cfgBcd  (cfgBcd),
    .rdFire  (rdFire)
  );

  tmr_dpath #(.CH_NUM(CH_NUM), .CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgAcc    (cfgAcc),
    .cfgMode   (cfgMode),
    .cfgBcd    (cfgBcd),
    .rdFire    (rdFire),
    .wrByte    (wrData),
    .liveCount (liveCount),
    .chanOut   (chanOut),
    .reloadVal (reloadVal),
    .loadStb   (loadStb),
    .chanMode  (chanMode),
    .rdData    (rdData)
  );

  // R3: at most one channel reloads per cycle
  a_r3_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStb));

endmodule

// File: tb/sim_tmr_front.sv
module sim_tmr_front;

  localparam int CLK_PERIOD = 10;
  localparam int CH = 3;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [1:0]    addr = '0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdData;
  logic [CH*CW-1:0] liveCount = '0;
  logic [CH-1:0] chanOut = '0;
  logic [CH*CW-1:0] reloadVal;
  logic [CH-1:0] loadStb;
  logic [CH*3-1:0] chanMode;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit rdSeen = 0;

  logic [7:0] expRd[$];
  string      tagRd[$];
  int         expLdCh[$];
  logic [CW-1:0] expLdVal[$];
  string      tagLd[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_front u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .liveCount(liveCount),
    .chanOut(chanOut), .reloadVal(reloadVal), .loadStb(loadStb),
    .chanMode(chanMode)
  );

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdSeen <= rdEn && !wrEn;

  // monitor: compares outputs against the scoreboard queues
  always @(negedge clk) if (rstN && !finished) begin
    if (rdSeen) begin
      if (expRd.size() == 0) check("R12 unexpected read", rdData, 8'hxx);
      else check(tagRd.pop_front(), rdData, expRd.pop_front());
    end
    if (loadStb != '0) begin
      if (expLdCh.size() == 0) check("R3 unexpected load", CW'(loadStb), '0);
      else begin
        automatic int c = expLdCh.pop_front();
        automatic string t = tagLd.pop_front();
        check(t, CW'(loadStb), CW'(1 << c));
        check(t, reloadVal[c*CW +: CW], expLdVal.pop_front());
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrLoad(int c, logic [7:0] d, logic [CW-1:0] v, string t);
    expLdCh.push_back(c); expLdVal.push_back(v); tagLd.push_back(t);
    wr(2'(c), d);
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string t);
    expRd.push_back(e); tagRd.push_back(t);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    liveCount = {16'h5A0F, 16'hABCD, 16'h1234};
    chanOut = 3'b101;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rdData", CW'(rdData), 16'h0);
    check("R1 loadStb", CW'(loadStb), 16'h0);
    check("R1 chanMode", CW'(chanMode), 16'h0);
    rd(2'd0, 8'h34, "R1 R11 word low");
    rd(2'd0, 8'h12, "R1 R11 word high");

    // R2/R3: ch0 low-byte access, mode 2
    wr(2'd3, 8'h14);
    check("R2 ch0 mode", CW'(chanMode[2:0]), 16'd2);
    wrLoad(0, 8'h77, 16'h0077, "R3 low-byte load");
    rd(2'd0, 8'h34, "R11 low-byte live");
    rd(2'd0, 8'h34, "R11 low-byte no alternate");

    // R4: ch1 high-byte access, mode 3, bcd
    wr(2'd3, 8'h67);
    wrLoad(1, 8'h9C, 16'h9C00, "R4 high-byte load");
    rd(2'd1, 8'hAB, "R11 high-byte live");

    // R5: ch2 word access, mode 7 stored as 3
    wr(2'd3, 8'hBE);
    check("R2 mode 7 maps to 3", CW'(chanMode[8:6]), 16'd3);
    wr(2'd2, 8'h11);
    check("R5 no load after first byte", CW'(loadStb), 16'h0);
    wrLoad(2, 8'h22, 16'h2211, "R5 word load");
    rd(2'd2, 8'h0F, "R11 word alt low");
    rd(2'd2, 8'h5A, "R11 word alt high");
    rd(2'd2, 8'h0F, "R11 word alt low again");
    wr(2'd2, 8'h33);
    wr(2'd3, 8'hBE);
    wr(2'd2, 8'h44);
    check("R2 write pointer restart", CW'(loadStb), 16'h0);
    wrLoad(2, 8'h55, 16'h5544, "R2 R5 load after restart");

    // R6/R10: count latch once, word readout
    wr(2'd3, 8'h80);
    liveCount[2*CW +: CW] = 16'h6789;
    wr(2'd3, 8'h80);
    rd(2'd2, 8'h0F, "R6 R10 latched low");
    rd(2'd2, 8'h5A, "R6 R10 latched high");
    rd(2'd2, 8'h89, "R10 latch released, R2 read pointer restart");

    // R7/R8/R9/R10: read-back on ch0 and ch1
    wr(2'd3, 8'hC6);
    liveCount[0 +: CW] = 16'h4321;
    liveCount[CW +: CW] = 16'h1111;
    rd(2'd0, 8'h94, "R7 R8 R9 ch0 status");
    rd(2'd0, 8'h34, "R9 R10 ch0 latched low-byte");
    rd(2'd0, 8'h21, "R10 ch0 released");
    rd(2'd1, 8'h27, "R7 R8 ch1 status");
    rd(2'd1, 8'hAB, "R10 ch1 latched high-byte");
    rd(2'd1, 8'h11, "R10 ch1 released");
    rd(2'd2, 8'h67, "R7 ch2 not selected, live");

    // R8: status latch once
    wr(2'd3, 8'hE8);
    chanOut[2] = 1'b0;
    wr(2'd3, 8'hE8);
    rd(2'd2, 8'hB6, "R8 status latched once");
    rd(2'd2, 8'h89, "R9 status cleared, live");

    // R12: hold and control address read
    repeat (3) @(negedge clk);
    check("R12 rdData holds", CW'(rdData), 16'h89);
    rd(2'd3, 8'h00, "R12 control address read");
    wrEn = 1'b1; rdEn = 1'b1; addr = 2'd1; wrData = 8'h5E;
    expLdCh.push_back(1); expLdVal.push_back(16'h5E00); tagLd.push_back("R12 write wins");
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R12 read dropped", CW'(rdData), 16'h00);
    check("R2 final modes", CW'(chanMode), CW'({3'd3, 3'd3, 3'd2}));

    repeat (2) @(negedge clk);
    check("R12 read queue drained", CW'(expRd.size()), 16'd0);
    check("R3 load queue drained", CW'(expLdCh.size()), 16'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule